// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller

This block is an eight-input programmable interrupt controller. Software reaches it through a byte-wide register interface. A single address bit picks one of two ports: the command port (`addr = 0`) or the data port (`addr = 1`). The controller holds three 8-bit registers. The request register latches incoming interrupts, the in-service register records interrupts being handled, and the mask register blocks inputs.

Before the unit accepts anything it must be programmed with a four-word initialization sequence, and it checks that sequence. After that, operation commands load the mask, issue end-of-interrupt, move the rotating priority pointer, and choose which register the command port returns on a read.

The unit picks the highest-ranked eligible request and raises a registered interrupt line. It holds that line until `ack`. On `ack` the vector is presented, and the request moves into in-service, unless automatic end-of-interrupt is enabled. Inputs on `irq_in` are already conditioned one-cycle request strobes. Cascading of several units and polled operation are not provided.

Top module: `prio_intc`

## Requirements
- R1: After reset, `int_out` is 0, all three registers read 0, and the unit is not ready. While the unit is not ready, `irq_in` is ignored, so the request register stays 0.
- R2: Initialization runs in four steps:
  - A command-port write with bit 4 set starts it.
  - Three data-port writes follow.
  - The second word's bits 7:3 become the vector base.
  - The third word is ignored.
  - The fourth word with bit 0 set makes the unit ready, and its bit 1 enables automatic EOI.
  - The vector is `{base, pin}`.
- R3: A start word clears the mask, request and in-service registers, resets the pointer to 0, disables rotate, poll and automatic EOI, selects request readback, and drops `int_out`. The sequence is rejected, leaving the unit not ready, in either of these cases:
  - the start word has bit 1 set or bit 0 clear;
  - the fourth word has bit 0 clear.
- R4: Ranking follows the priority pointer P. Rank 0 (highest) is input P+1 mod 8, then P+2 mod 8, and so on. Input P itself ranks lowest.
- R5: An input is eligible only when all three of these hold: its request bit is set, its mask bit is clear, and it ranks strictly above every set in-service bit.
- R6: `int_out` rises on the cycle after an eligible input is found while ready. It then stays high until `ack`, even if the request is masked in the meantime. It is low on the cycle after `ack`.
- R7: During `ack`, `vector` is the base plus the eligible input. On that edge the input's request bit is cleared and its in-service bit is set. With nothing eligible, `vector` is base plus 7 and no register changes.
- R8: With automatic EOI on, `ack` sets no in-service bit. If rotate is also on, the pointer moves to the acknowledged input.
- R9: A command word with bit 3 clear and bit 5 set is an EOI:
  - With bit 6 set, it clears the in-service bit named by bits 2:0.
  - With bit 6 clear, it clears the highest-ranked set in-service bit.
  - Bit 7 sets rotate mode. With rotate on, the cleared input becomes the pointer.
- R10: A command word with bit 3 clear, bit 5 clear, and bits 7 and 6 set loads the pointer from bits 2:0.
- R11: A command word with bit 3 set selects the readback. When bit 1 is set, bit 0 chooses in-service (1) or request (0). A data-port read returns the mask. Once ready, a data-port write loads the mask.
- R12: Bit 2 of a bit-3 command word turns poll mode on or off. While poll is on, a read returns 0x00 and `rd_err` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | 0 = command port, 1 = data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while `rd_en` is high |
| rd_err | output | 1 | Read attempted while poll mode is on |
| irq_in | input | 8 | One-cycle request strobes, one per input |
| ack | input | 1 | Interrupt acknowledge |
| vector | output | 8 | Vector of the winning input, or spurious |
| int_out | output | 1 | Registered interrupt request |

## Verification
The bench targets these corner cases:
- **Rank ordering.** It moves the pointer so that the lowest-numbered input wins over the pointer input. A design ranking by plain input number, or ranking the pointer first, returns the wrong vector.
- **Nesting.** It holds one input in service while a lower-ranked one is pending. A design that compares against the pending request rather than against in-service raises `int_out` when it must stay low.
- **Masking while raised.** It masks a request while `int_out` is high. This must produce the spurious vector and no in-service change.
- **Automatic EOI with rotate.** It checks that the pointer follows the acknowledged input.
- **Rejected initialization.** Rejected start words and a bad fourth word must leave requests ignored.

// File: rtl/prio_intc.sv
module prio_intc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       rd_err,
  input  logic [7:0] irq_in,
  input  logic       ack,
  output logic [7:0] vector,
  output logic       int_out
);
  localparam logic [1:0] S_IDLE = 2'd0, S_W2 = 2'd1, S_W3 = 2'd2, S_W4 = 2'd3;

  logic [7:0] irr, isr, imr, irr_n, isr_n, imr_n;
  logic [2:0] prio, prio_n;
  logic [4:0] base, base_n;
  logic [1:0] step, step_n;
  logic ready, aeoi, poll, rot, sel_isr, int_n;
  logic ready_n, aeoi_n, poll_n, rot_n, sel_n;
  logic hit, isr_hit;
  logic [2:0] top, isr_top;

  function automatic logic [2:0] rk(input logic [2:0] pr, input int i);
    return pr + 3'(i + 1);
  endfunction

  always_comb begin
    hit = 1'b0; top = 3'd0; isr_hit = 1'b0; isr_top = 3'd0;
    for (int i = 0; i < 8; i++) begin
      if (isr[rk(prio, i)] && !isr_hit) begin
        isr_hit = 1'b1;
        isr_top = rk(prio, i);
      end
      if (!isr_hit && !hit && irr[rk(prio, i)] && !imr[rk(prio, i)]) begin
        hit = 1'b1;
        top = rk(prio, i);
      end
    end
  end

  always_comb begin
    irr_n = irr; isr_n = isr; imr_n = imr; prio_n = prio; base_n = base;
    step_n = step; ready_n = ready; aeoi_n = aeoi; poll_n = poll;
    rot_n = rot; sel_n = sel_isr; int_n = int_out;

    if (ack) begin
      int_n = 1'b0;
      if (hit) begin
        irr_n[top] = 1'b0;
        if (aeoi) begin
          if (rot) prio_n = top;
        end else begin
          isr_n[top] = 1'b1;
        end
      end
    end else if (!int_out && hit && ready) begin
      int_n = 1'b1;
    end

    if (wr_en) begin
      if (!addr) begin
        if (wdata[4]) begin
          ready_n = 1'b0; imr_n = 8'h00; irr_n = 8'h00; isr_n = 8'h00;
          prio_n = 3'd0; sel_n = 1'b0; aeoi_n = 1'b0; poll_n = 1'b0;
          rot_n = 1'b0; int_n = 1'b0;
          step_n = (wdata[1] || !wdata[0]) ? S_IDLE : S_W2;
        end else if (ready) begin
          if (wdata[3]) begin
            poll_n = wdata[2];
            if (wdata[1]) sel_n = wdata[0];
          end else begin
            rot_n = wdata[7];
            if (wdata[5]) begin
              if (wdata[6]) begin
                isr_n[wdata[2:0]] = 1'b0;
                if (wdata[7]) prio_n = wdata[2:0];
              end else if (isr_hit) begin
                isr_n[isr_top] = 1'b0;
                if (wdata[7]) prio_n = isr_top;
              end
            end else if (wdata[6] && wdata[7]) begin
              prio_n = wdata[2:0];
            end
          end
        end
      end else begin
        case (step)
          S_W2: begin base_n = wdata[7:3]; step_n = S_W3; end
          S_W3: step_n = S_W4;
          S_W4: begin
            if (wdata[0]) begin
              aeoi_n = wdata[1];
              ready_n = 1'b1;
            end
            step_n = S_IDLE;
          end
          default: if (ready) imr_n = wdata;
        endcase
      end
    end

    if (ready) irr_n = irr_n | irq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr <= '0; isr <= '0; imr <= '0; prio <= '0; base <= '0; step <= S_IDLE;
      ready <= 1'b0; aeoi <= 1'b0; poll <= 1'b0; rot <= 1'b0;
      sel_isr <= 1'b0; int_out <= 1'b0;
    end else begin
      irr <= irr_n; isr <= isr_n; imr <= imr_n; prio <= prio_n; base <= base_n;
      step <= step_n; ready <= ready_n; aeoi <= aeoi_n; poll <= poll_n;
      rot <= rot_n; sel_isr <= sel_n; int_out <= int_n;
    end
  end

  assign rdata  = (!rd_en || poll) ? 8'h00 : (addr ? imr : (sel_isr ? isr : irr));
  assign rd_err = rd_en && poll;
  assign vector = {base, hit ? top : 3'd7};
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ack,
  input logic       wr_en,
  input logic       addr,
  input logic [7:0] wdata,
  input logic       int_out,
  input logic       ready,
  input logic       hit,
  input logic [2:0] top,
  input logic       aeoi,
  input logic [7:0] isr,
  input logic [7:0] imr
);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int_out && !ack && !(wr_en && !addr && wdata[4])) |=> int_out);

  p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !int_out);

  p_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_out) |-> $past(ready && hit));

  p_isr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && hit && !aeoi && !(wr_en && !addr)) |=> isr[$past(top)]);

  p_aeoi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && hit && aeoi && !isr[top] && !(wr_en && !addr)) |=> !isr[$past(top)]);

  p_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4]) |=> (!ready && imr == 8'h00));
endmodule

bind prio_intc prio_intc_chk u_chk (.*);

// File: tb/sim_prio_intc.sv
module sim_prio_intc;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, ack = 1'b0;
  logic [7:0] wdata = 8'h00, irq_in = 8'h00;
  logic [7:0] rdata, vector;
  logic rd_err, int_out;
  int total = 0, bad = 0;
  bit finished = 0;

  prio_intc u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_err(rd_err), .irq_in(irq_in), .ack(ack),
    .vector(vector), .int_out(int_out));

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d, output logic e);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1; d = rdata; e = rd_err; rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk); irq_in = m;
    @(negedge clk); irq_in = 8'h00;
  endtask

  task automatic do_ack(output logic [7:0] v);
    @(negedge clk); ack = 1'b1;
    #1; v = vector;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic init(input logic [7:0] b, input logic [7:0] w4);
    wr(0, 8'h11); wr(1, b); wr(1, 8'h00); wr(1, w4);
  endtask

  function automatic logic [3:0] model(input logic [7:0] r, input logic [7:0] m,
                                       input logic [7:0] s, input logic [2:0] pr);
    for (int i = 0; i < 8; i++) begin
      logic [2:0] p;
      p = pr + 3'(i + 1);
      if (s[p]) return 4'h0;
      if (r[p] && !m[p]) return {1'b1, p};
    end
    return 4'h0;
  endfunction

  initial begin
    #(4 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, v, irr_m, isr_m, imr_m, m;
    logic [2:0] prio_m;
    logic [3:0] e;
    logic er;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, requests ignored while not ready
    chk("R1 int_out", {7'd0, int_out}, 8'h00);
    rd(1, d, er); chk("R1 mask", d, 8'h00);
    pulse(8'hFF); @(negedge clk);
    rd(0, d, er); chk("R1 req ignored", d, 8'h00);
    chk("R1 no int", {7'd0, int_out}, 8'h00);

    // R3 rejected start words and bad fourth word
    wr(0, 8'h13); wr(1, 8'h40); wr(1, 8'h00); wr(1, 8'h01);
    pulse(8'h01); @(negedge clk);
    rd(0, d, er); chk("R3 single rejected", d, 8'h00);
    wr(0, 8'h10); wr(1, 8'h40); wr(1, 8'h00); wr(1, 8'h01);
    pulse(8'h01); @(negedge clk);
    rd(0, d, er); chk("R3 no word4 rejected", d, 8'h00);
    init(8'h40, 8'h00);
    pulse(8'h01); @(negedge clk);
    rd(0, d, er); chk("R3 bad word4 rejected", d, 8'h00);

    // R2 good init, R6 raise, R7 ack
    init(8'h47, 8'h01);
    pulse(8'h08); @(negedge clk);
    chk("R6 raised", {7'd0, int_out}, 8'h01);
    do_ack(v); chk("R2 R7 vector", v, 8'h43);
    chk("R6 dropped", {7'd0, int_out}, 8'h00);
    wr(0, 8'h0B); rd(0, d, er); chk("R11 R7 isr readback", d, 8'h08);
    wr(0, 8'h0A); rd(0, d, er); chk("R7 req cleared", d, 8'h00);

    // R9 non-specific EOI, R4 order, R5 nesting
    wr(0, 8'h20);
    wr(0, 8'h0B); rd(0, d, er); chk("R9 nonspecific eoi", d, 8'h00);
    pulse(8'h03); @(negedge clk);
    do_ack(v); chk("R4 pin1 over pin0", v, 8'h41);
    @(negedge clk); @(negedge clk);
    chk("R5 pin0 blocked", {7'd0, int_out}, 8'h00);
    wr(0, 8'h61);
    @(negedge clk);
    chk("R9 specific eoi unblocks", {7'd0, int_out}, 8'h01);
    do_ack(v); chk("R4 pin0 vector", v, 8'h40);
    wr(0, 8'h20);

    // R6 held while masked, spurious vector
    pulse(8'h20); @(negedge clk);
    wr(1, 8'hFF);
    chk("R6 held when masked", {7'd0, int_out}, 8'h01);
    do_ack(v); chk("R7 spurious", v, 8'h47);
    rd(0, d, er); chk("R7 spurious no isr", d, 8'h00);
    rd(1, d, er); chk("R11 mask readback", d, 8'hFF);
    wr(1, 8'h00); @(negedge clk);
    do_ack(v); chk("R7 pending after unmask", v, 8'h45);
    wr(0, 8'h20);

    // R10 set pointer, R9 rotating EOI
    wr(0, 8'hC4);
    pulse(8'h11); @(negedge clk);
    do_ack(v); chk("R10 pointer 4 picks pin0", v, 8'h40);
    wr(0, 8'hA0);
    @(negedge clk);
    do_ack(v); chk("R9 rotate to pointer 0", v, 8'h44);
    wr(0, 8'hE4);
    rd(0, d, er); chk("R9 rotating specific eoi", d, 8'h00);

    // R8 automatic EOI with rotate
    init(8'h20, 8'h03);
    wr(0, 8'h80);
    pulse(8'h40); @(negedge clk);
    do_ack(v); chk("R8 aeoi vector", v, 8'h26);
    wr(0, 8'h0B); rd(0, d, er); chk("R8 no isr", d, 8'h00);
    pulse(8'h41); @(negedge clk);
    do_ack(v); chk("R8 pointer moved", v, 8'h20);
    @(negedge clk);
    do_ack(v); chk("R8 pin6 last", v, 8'h26);

    // R12 poll
    wr(1, 8'hA5);
    wr(0, 8'h0C); rd(1, d, er);
    chk("R12 poll data", d, 8'h00); chk("R12 poll err", {7'd0, er}, 8'h01);
    wr(0, 8'h08); rd(1, d, er);
    chk("R11 mask after poll", d, 8'hA5); chk("R12 err clear", {7'd0, er}, 8'h00);

    // random phase with rotating EOI
    init(8'h80, 8'h01);
    irr_m = 0; isr_m = 0; imr_m = 0; prio_m = 0;
    for (int n = 0; n < 300; n++) begin
      if ($urandom % 3 == 0 && isr_m != 0) begin
        wr(0, 8'hA0);
        for (int i = 0; i < 8; i++) begin
          logic [2:0] p;
          p = prio_m + 3'(i + 1);
          if (isr_m[p]) begin isr_m[p] = 1'b0; prio_m = p; break; end
        end
      end
      if ($urandom % 2 == 0) begin m = 8'($urandom); wr(1, m); imr_m = m; end
      m = 8'($urandom) & 8'($urandom);
      pulse(m); irr_m = irr_m | m;
      @(negedge clk);
      for (int k = 0; k < 10; k++) begin
        e = model(irr_m, imr_m, isr_m, prio_m);
        if (e[3]) begin
          chk("R6 rand raise", {7'd0, int_out}, 8'h01);
          do_ack(v); chk("R4 R5 R7 rand vector", v, {5'h10, e[2:0]});
          irr_m[e[2:0]] = 1'b0; isr_m[e[2:0]] = 1'b1;
          @(negedge clk);
        end else if (int_out) begin
          do_ack(v); chk("R7 rand spurious", v, 8'h87);
          @(negedge clk);
        end else break;
      end
      chk("R5 rand quiet", {7'd0, int_out}, 8'h00);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule